// File: doc/BRIEF.md
# PLL Divider Parameter Search Engine

This block takes a requested output frequency in kHz and searches for the reference divider M, the feedback multiplier N and the power-of-two post divider P that bring a PLL output, defined as (fref / M) * N / P, closest to the request. Besides the request, it takes four configuration values: the reference frequency, the VCO minimum and maximum, and the largest allowed output frequency. The search runs on integer kHz values.

A one-cycle `start` pulse latches the request and the configuration. The engine first clamps the request into the range the PLL can reach. It then walks the post-divider exponents and, inside each, the reference-divider values, computing a rounded N for every candidate. A single shared shift-subtract divider performs both divisions of each candidate. The lowest error seen so far is held in a register. When the walk ends, a one-cycle `done` pulse presents the best setting, the packed programming word and the achieved frequency. If no candidate is valid, `no_solution` is raised with `done` and all result fields are zero.

The controller is a single enumerated state machine. `S_IDLE` goes to `S_CLAMP` on start. `S_CLAMP` goes to `S_P_CHECK`. `S_P_CHECK` goes to `S_FINISH` after the last exponent, to `S_M_CHECK` when the VCO range admits the current exponent, and otherwise stays and advances the exponent. `S_M_CHECK` goes back to `S_P_CHECK` after the last M, to `S_N_DIV` (launching the N division) when the phase-comparator window admits M, and otherwise stays and advances M. `S_N_DIV` waits for the quotient and goes to `S_N_CHECK`. `S_N_CHECK` goes back to `S_M_CHECK` for an out-of-range N, and otherwise launches the frequency division and goes to `S_F_DIV`. `S_F_DIV` waits for the quotient and goes to `S_COMPARE`. `S_COMPARE` updates the best setting and returns to `S_M_CHECK`. `S_FINISH` returns to `S_IDLE`.

Top module: `pll_search_engine`

## Requirements
- R1: After reset, `busy`, `done` and `no_solution` are 0, and `m_out`, `n_out`, `p_code`, `pll_word` and `fout_khz` are all zero.
- R2: A `start` pulse in idle raises `busy` on the next cycle. `done` is high for exactly one cycle per accepted start, and `busy` falls after it. A `start` while busy is ignored: it produces no extra `done` and leaves the results of the running search unchanged.
- R3: The request is first raised to floor(vco_min/16) if it is below that value, and then lowered to `fout_max_khz` if it is above that value. The clamped value is the target for all later steps.
- R4: The post divider P takes the values 1, 2, 4, 8 and 16 in that order. A P is used only when request*P lies within [vco_min, vco_max], with both bounds inclusive.
- R5: M runs from 7 to 14 in ascending order inside each P. An M is used only when 1000*M <= fref <= 2000*M, which keeps fref/M within 1 to 2 MHz.
- R6: N = floor((request*P*M + floor(fref/2)) / fref). A candidate with N = 0 or N > 255 is rejected.
- R7: The achieved frequency is floor((fref*N + floor(M*P/2)) / (M*P)), and the error is the absolute difference between it and the clamped request. A candidate replaces the stored best only if its error is strictly smaller, so the earliest candidate in P-then-M order wins ties. `fout_khz` reports the achieved frequency of the winner.
- R8: `p_code` is log2(P), from 0 for P=1 to 4 for P=16. `pll_word` holds P code in bits 23:16, N in bits 15:8 and M in bits 7:0.
- R9: If no candidate survives the checks, `no_solution` is 1 during the `done` cycle, and M, N, P code, word and frequency are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search; ignored while busy |
| req_khz | input | FREQ_W | Requested output frequency, kHz |
| fref_khz | input | FREQ_W | Reference frequency, kHz |
| vco_min_khz | input | FREQ_W | Lowest allowed VCO frequency, kHz |
| vco_max_khz | input | FREQ_W | Highest allowed VCO frequency, kHz |
| fout_max_khz | input | FREQ_W | Highest allowed output frequency, kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| no_solution | output | 1 | No valid setting was found |
| m_out | output | 8 | Selected reference divider |
| n_out | output | 8 | Selected feedback multiplier |
| p_code | output | 3 | log2 of selected post divider |
| pll_word | output | 24 | Packed {P code, N, M} |
| fout_khz | output | FREQ_W+1 | Achieved output frequency, kHz |

## Verification
The bench targets ties where several (P, M) pairs hit the request exactly. A design that replaced the best on equal error would report the last pair, not the first. It drives requests far below the low clamp and far above the output limit. A design that clamped in the wrong order, or not at all, would select a post divider or frequency different from the hand-computed one. It builds configurations in which no P passes the VCO range or no M passes the comparator window, where a faulty design would report a stale or nonzero setting without `no_solution`. It also pulses start in the middle of a search, where a design that accepted it would emit an extra `done` or switch to the second request.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CLAMP,
        S_P_CHECK,
        S_M_CHECK,
        S_N_DIV,
        S_N_CHECK,
        S_F_DIV,
        S_COMPARE,
        S_FINISH
    } search_state_t;

endpackage

// File: rtl/pll_div_seq.sv
module pll_div_seq #(
    parameter int unsigned W = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient
);

    localparam int unsigned CW = $clog2(W + 1);

    logic [W-1:0]  acc;
    logic [W-1:0]  quo;
    logic [W-1:0]  dvs;
    logic [W-1:0]  dvd_q;
    logic [CW-1:0] cnt;
    logic          run;
    logic [W:0]    shifted;
    logic [W:0]    diff;
    logic          fits;

    always_comb begin
        shifted = {acc, quo[W-1]};
        fits    = shifted >= {1'b0, dvs};
        diff    = shifted - {1'b0, dvs};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc   <= '0;
            quo   <= '0;
            dvs   <= '0;
            dvd_q <= '0;
            cnt   <= '0;
            run   <= 1'b0;
            done  <= 1'b0;
        end else if (start) begin
            acc   <= '0;
            quo   <= dividend;
            dvs   <= divisor;
            dvd_q <= dividend;
            cnt   <= CW'(W);
            run   <= 1'b1;
            done  <= 1'b0;
        end else if (run) begin
            acc  <= fits ? diff[W-1:0] : shifted[W-1:0];
            quo  <= {quo[W-2:0], fits};
            cnt  <= cnt - 1'b1;
            run  <= (cnt != CW'(1));
            done <= (cnt == CW'(1));
        end else begin
            done <= 1'b0;
        end
    end

    assign quotient = quo;

    // R6: every quotient satisfies q*d + r == dividend with r < d
    assert_div_exact_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (((2*W)'(quo) * (2*W)'(dvs) + (2*W)'(acc)) == (2*W)'(dvd_q)) && (acc < dvs));

endmodule

// File: rtl/pll_range_gate.sv
module pll_range_gate #(
    parameter int unsigned FREQ_W     = 20,
    parameter int unsigned FV_W       = 24,
    parameter int unsigned MW         = 4,
    parameter int unsigned PD_MIN_KHZ = 1000,
    parameter int unsigned PD_MAX_KHZ = 2000
) (
    input  logic [FV_W-1:0]   fvco,
    input  logic [FREQ_W-1:0] vco_min,
    input  logic [FREQ_W-1:0] vco_max,
    input  logic [FREQ_W-1:0] fref,
    input  logic [MW-1:0]     m_val,
    output logic              p_ok,
    output logic              m_ok
);

    localparam int unsigned LW = FREQ_W + MW + 12;

    logic [LW-1:0] lo_lim;
    logic [LW-1:0] hi_lim;

    always_comb begin
        p_ok   = (fvco >= FV_W'(vco_min)) && (fvco <= FV_W'(vco_max));
        lo_lim = LW'(PD_MIN_KHZ) * LW'(m_val);
        hi_lim = LW'(PD_MAX_KHZ) * LW'(m_val);
        m_ok   = (LW'(fref) >= lo_lim) && (LW'(fref) <= hi_lim);
    end

endmodule

// File: rtl/pll_search_engine.sv
module pll_search_engine
    import pll_search_pkg::*;
#(
    parameter int unsigned FREQ_W     = 20,
    parameter int unsigned PD_MIN_KHZ = 1000,
    parameter int unsigned PD_MAX_KHZ = 2000,
    parameter int unsigned M_FIRST    = 7,
    parameter int unsigned M_LAST     = 14,
    parameter int unsigned P_EXP_MAX  = 4,
    parameter int unsigned N_MAX      = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FREQ_W-1:0] req_khz,
    input  logic [FREQ_W-1:0] fref_khz,
    input  logic [FREQ_W-1:0] vco_min_khz,
    input  logic [FREQ_W-1:0] vco_max_khz,
    input  logic [FREQ_W-1:0] fout_max_khz,
    output logic              busy,
    output logic              done,
    output logic              no_solution,
    output logic [7:0]        m_out,
    output logic [7:0]        n_out,
    output logic [2:0]        p_code,
    output logic [23:0]       pll_word,
    output logic [FREQ_W:0]   fout_khz
);

    localparam int unsigned FV_W  = FREQ_W + P_EXP_MAX;
    localparam int unsigned MW    = $clog2(M_LAST + 2);
    localparam int unsigned PW    = $clog2(P_EXP_MAX + 2);
    localparam int unsigned AW    = FREQ_W + 1;
    localparam int unsigned DIV_A = FV_W + MW;
    localparam int unsigned DIV_B = FREQ_W + 8;
    localparam int unsigned DIV_W = (DIV_A > DIV_B) ? DIV_A : DIV_B;

    search_state_t state, state_nx;

    logic [FREQ_W-1:0] req_q, fref_q, vmin_q, vmax_q, fmax_q;
    logic [PW-1:0]     p_exp;
    logic [MW-1:0]     m_cur;
    logic [DIV_W-1:0]  n_full;
    logic [AW-1:0]     ach;
    logic [MW-1:0]     best_m;
    logic [7:0]        best_n;
    logic [PW-1:0]     best_p;
    logic [AW-1:0]     best_f, best_err;
    logic              best_valid;

    logic [FV_W-1:0]   fvco;
    logic              p_ok, m_ok;
    logic              p_end, m_end, n_bad;
    logic [FREQ_W-1:0] clamp_lo, req_lo, req_cl;
    logic [AW-1:0]     err;
    logic [DIV_W-1:0]  dsum;
    logic              div_start, div_done;
    logic [DIV_W-1:0]  div_a, div_b, div_q;

    assign fvco  = FV_W'(req_q) << p_exp;
    assign p_end = p_exp > PW'(P_EXP_MAX);
    assign m_end = m_cur > MW'(M_LAST);
    assign n_bad = (n_full == '0) || (n_full > DIV_W'(N_MAX));
    assign dsum  = DIV_W'(m_cur) << p_exp;
    assign err   = (ach > AW'(req_q)) ? (ach - AW'(req_q)) : (AW'(req_q) - ach);

    always_comb begin
        clamp_lo = vmin_q >> P_EXP_MAX;
        req_lo   = (req_q < clamp_lo) ? clamp_lo : req_q;
        req_cl   = (req_lo > fmax_q) ? fmax_q : req_lo;
    end

    pll_range_gate #(
        .FREQ_W(FREQ_W), .FV_W(FV_W), .MW(MW),
        .PD_MIN_KHZ(PD_MIN_KHZ), .PD_MAX_KHZ(PD_MAX_KHZ)
    ) u_gate (
        .fvco(fvco), .vco_min(vmin_q), .vco_max(vmax_q),
        .fref(fref_q), .m_val(m_cur), .p_ok(p_ok), .m_ok(m_ok)
    );

    pll_div_seq #(.W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start),
        .dividend(div_a), .divisor(div_b),
        .done(div_done), .quotient(div_q)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (start) state_nx = S_CLAMP;
            S_CLAMP:   state_nx = S_P_CHECK;
            S_P_CHECK: begin
                if (p_end)     state_nx = S_FINISH;
                else if (p_ok) state_nx = S_M_CHECK;
            end
            S_M_CHECK: begin
                if (m_end)     state_nx = S_P_CHECK;
                else if (m_ok) state_nx = S_N_DIV;
            end
            S_N_DIV:   if (div_done) state_nx = S_N_CHECK;
            S_N_CHECK: state_nx = n_bad ? S_M_CHECK : S_F_DIV;
            S_F_DIV:   if (div_done) state_nx = S_COMPARE;
            S_COMPARE: state_nx = S_M_CHECK;
            S_FINISH:  state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // outputs and divider launch
    always_comb begin
        busy      = (state != S_IDLE);
        done      = (state == S_FINISH);
        div_start = 1'b0;
        div_a     = DIV_W'(fvco) * DIV_W'(m_cur) + DIV_W'(fref_q >> 1);
        div_b     = DIV_W'(fref_q);
        if (state == S_M_CHECK && !m_end && m_ok) begin
            div_start = 1'b1;
        end else if (state == S_N_CHECK) begin
            div_start = !n_bad;
            div_a     = DIV_W'(fref_q) * DIV_W'(n_full[7:0]) + (dsum >> 1);
            div_b     = dsum;
        end
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0; fref_q <= '0; vmin_q <= '0; vmax_q <= '0; fmax_q <= '0;
            p_exp <= '0; m_cur <= '0; n_full <= '0; ach <= '0;
            best_m <= '0; best_n <= '0; best_p <= '0; best_f <= '0; best_err <= '0;
            best_valid <= 1'b0;
            no_solution <= 1'b0;
            m_out <= '0; n_out <= '0; p_code <= '0; fout_khz <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    req_q      <= req_khz;
                    fref_q     <= fref_khz;
                    vmin_q     <= vco_min_khz;
                    vmax_q     <= vco_max_khz;
                    fmax_q     <= fout_max_khz;
                    best_valid <= 1'b0;
                end
                S_CLAMP: begin
                    req_q <= req_cl;
                    p_exp <= '0;
                end
                S_P_CHECK: begin
                    if (p_end) begin
                        no_solution <= !best_valid;
                        m_out       <= best_valid ? 8'(best_m) : 8'd0;
                        n_out       <= best_valid ? best_n : 8'd0;
                        p_code      <= best_valid ? 3'(best_p) : 3'd0;
                        fout_khz    <= best_valid ? best_f : '0;
                    end else if (p_ok) begin
                        m_cur <= MW'(M_FIRST);
                    end else begin
                        p_exp <= p_exp + 1'b1;
                    end
                end
                S_M_CHECK: begin
                    if (m_end)      p_exp <= p_exp + 1'b1;
                    else if (!m_ok) m_cur <= m_cur + 1'b1;
                end
                S_N_DIV:   if (div_done) n_full <= div_q;
                S_N_CHECK: if (n_bad) m_cur <= m_cur + 1'b1;
                S_F_DIV:   if (div_done) ach <= div_q[AW-1:0];
                S_COMPARE: begin
                    if (!best_valid || err < best_err) begin
                        best_valid <= 1'b1;
                        best_err   <= err;
                        best_m     <= m_cur;
                        best_n     <= n_full[7:0];
                        best_p     <= p_exp;
                        best_f     <= ach;
                    end
                    m_cur <= m_cur + 1'b1;
                end
                S_FINISH: ;
                default: ;
            endcase
        end
    end

    assign pll_word = {5'd0, p_code, n_out, m_out};

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);
    assert_done_drops_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    assert_sel_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_solution) |-> (m_out >= 8'(M_FIRST)) && (m_out <= 8'(M_LAST)));
    assert_n_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_solution) |-> (n_out != 8'd0));
    assert_pcode_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_solution) |-> (p_code <= 3'(P_EXP_MAX)));
    assert_nosol_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && no_solution) |-> (pll_word == 24'd0) && (fout_khz == '0));
    assert_cand_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_N_DIV && $past(state) == S_M_CHECK) |->
        ($past(m_cur) >= MW'(M_FIRST)) && ($past(m_cur) <= MW'(M_LAST)));

endmodule

// File: tb/pll_search_engine_bench.sv
module pll_search_engine_bench;

    localparam int FREQ_W = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [FREQ_W-1:0] req_khz = '0, fref_khz = '0, vco_min_khz = '0, vco_max_khz = '0, fout_max_khz = '0;
    logic              busy, done, no_solution;
    logic [7:0]        m_out, n_out;
    logic [2:0]        p_code;
    logic [23:0]       pll_word;
    logic [FREQ_W:0]   fout_khz;

    always #10 clk = ~clk;

    pll_search_engine u_pll_search_engine (
        .clk(clk), .rst_n(rst_n), .start(start),
        .req_khz(req_khz), .fref_khz(fref_khz), .vco_min_khz(vco_min_khz),
        .vco_max_khz(vco_max_khz), .fout_max_khz(fout_max_khz),
        .busy(busy), .done(done), .no_solution(no_solution),
        .m_out(m_out), .n_out(n_out), .p_code(p_code),
        .pll_word(pll_word), .fout_khz(fout_khz)
    );

    typedef struct {
        logic nosol;
        int   m;
        int   n;
        int   p;
        int   f;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    failures = 0;
    int    done_seen = 0;
    logic  done_prev = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    function automatic exp_t model(input longint req, input longint fref, input longint vmin,
                                   input longint vmax, input longint fmax);
        exp_t   e;
        longint r, fv, n, d, a, er, be;
        bit     found;
        r = req;
        if (r < (vmin >> 4)) r = vmin >> 4;
        if (r > fmax) r = fmax;
        found = 0; be = 0;
        e.nosol = 1; e.m = 0; e.n = 0; e.p = 0; e.f = 0;
        for (int p = 0; p <= 4; p++) begin
            fv = r << p;
            if (fv < vmin || fv > vmax) continue;
            for (int m = 7; m <= 14; m++) begin
                if (fref < 1000 * m || fref > 2000 * m) continue;
                n = (fv * m + fref / 2) / fref;
                if (n < 1 || n > 255) continue;
                d = m << p;
                a = (fref * n + d / 2) / d;
                er = (a > r) ? a - r : r - a;
                if (!found || er < be) begin
                    found = 1; be = er;
                    e.nosol = 0; e.m = m; e.n = int'(n); e.p = p; e.f = int'(a);
                end
            end
        end
        return e;
    endfunction

    task automatic push_exp(input exp_t e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic launch(input int req, input int fref, input int vmin, input int vmax, input int fmax);
        @(negedge clk);
        req_khz = FREQ_W'(req); fref_khz = FREQ_W'(fref);
        vco_min_khz = FREQ_W'(vmin); vco_max_khz = FREQ_W'(vmax); fout_max_khz = FREQ_W'(fmax);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2", "busy after start", busy, 1);
    endtask

    task automatic wait_done();
        int target = done_seen + 1;
        while (done_seen < target) @(negedge clk);
        @(negedge clk);
        check(busy == 1'b0, "R2", "busy after done", busy, 0);
    endtask

    task automatic run_model(input int req, input int fref, input int vmin, input int vmax,
                             input int fmax, input string tag);
        push_exp(model(req, fref, vmin, vmax, fmax), tag);
        launch(req, fref, vmin, vmax, fmax);
        wait_done();
    endtask

    task automatic run_hand(input int req, input int fref, input int vmin, input int vmax, input int fmax,
                            input logic ns, input int m, input int n, input int p, input int f,
                            input string tag);
        exp_t e;
        e.nosol = ns; e.m = m; e.n = n; e.p = p; e.f = f;
        push_exp(e, tag);
        launch(req, fref, vmin, vmax, fmax);
        wait_done();
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (done && done_prev) check(0, "R2", "done longer than one cycle", 1, 0);
            if (done) begin
                if (exp_q.size() == 0) begin
                    check(0, "R2", "unexpected done", 1, 0);
                end else begin
                    exp_t  e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(no_solution == e.nosol, t, "no_solution", no_solution, e.nosol);
                    check(m_out == 8'(e.m) && n_out == 8'(e.n), t, "m*1000+n",
                          m_out * 1000 + n_out, e.m * 1000 + e.n);
                    check(p_code == 3'(e.p), t, "p_code", p_code, e.p);
                    check(fout_khz == (FREQ_W+1)'(e.f), t, "fout_khz", fout_khz, e.f);
                    check(pll_word == {8'(e.p), 8'(e.n), 8'(e.m)}, {t, " R8"}, "pll_word",
                          pll_word, (e.p << 16) | (e.n << 8) | e.m);
                end
                done_seen++;
            end
        end
        done_prev = done;
    end

    initial begin
        repeat (190000) @(posedge clk);
        check(0, "R2", "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        exp_t e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy == 0 && done == 0 && no_solution == 0, "R1", "status flags", {busy, done, no_solution}, 0);
        check(pll_word == 0 && fout_khz == 0, "R1", "result fields", pll_word, 0);

        // R7 exact hit with later ties: first pair (P=1,M=7,N=50) wins
        run_hand(100000, 14000, 100000, 200000, 400000, 1'b0, 7, 50, 0, 100000, "R7");
        // R3 low clamp: request raised to 6250, only P=16 passes (R4)
        run_hand(1, 14000, 100000, 200000, 400000, 1'b0, 7, 50, 4, 6250, "R3 R4");
        // R3 high clamp to 150000
        run_hand(999999, 14000, 100000, 200000, 150000, 1'b0, 7, 75, 0, 150000, "R3");
        // R9 no P in VCO range
        run_hand(100000, 14000, 300000, 200000, 400000, 1'b1, 0, 0, 0, 0, "R9 R4");
        // R9 no M passes comparator window (R5)
        run_hand(100000, 500, 100000, 200000, 400000, 1'b1, 0, 0, 0, 0, "R9 R5");
        // R5 narrow window: fref 28000 allows only M=14
        run_model(123457, 28000, 100000, 250000, 400000, "R5");
        // R6 N above limit pruned: low fref with high VCO
        run_model(60000, 7000, 100000, 900000, 400000, "R6");

        // R2 start while busy is ignored
        e = model(100000, 14000, 100000, 200000, 400000);
        push_exp(e, "R2");
        launch(100000, 14000, 100000, 200000, 400000);
        repeat (20) @(negedge clk);
        req_khz = FREQ_W'(150001);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (50) @(negedge clk);
        check(exp_q.size() == 0 && done_seen == 8, "R2", "done count", done_seen, 8);

        // R7 assorted configurations against the requirement model
        for (int i = 0; i < 16; i++) begin
            int fr, vl, vh, fm, rq;
            fr = $urandom_range(28000, 6000);
            vl = $urandom_range(200000, 80000);
            vh = vl + $urandom_range(260000, 20000);
            fm = $urandom_range(400000, 90000);
            rq = $urandom_range(500000, 1);
            run_model(rq, fr, vl, vh, fm, "R7");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule